// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block derives the sampling strobe for a serial port from the system clock. It emits a pulse one system clock wide at sixteen times the bit rate. The spacing of these pulses is set by a divisor with two parts: a whole number of clocks, and a fraction counted in sixty-fourths. The divisor is the clock frequency divided by sixteen times the baud rate. The whole part goes in one register. The fraction, rounded and scaled by 64, goes in another. Some periods are made one clock longer so that the average spacing comes out at the programmed value. For example, a 20 MHz clock at 115200 baud gives a whole part of 10 and a fraction of 54.

Software writes the two divisor parts through separate strobes, but they are only staged. The divisor in use changes on a write to the line-control strobe. A control strobe carries the enable bit. When the enable bit is cleared while the transmit or receive engine reports busy, the strobe keeps running until the character finishes. Only then does the block go idle.

Top module: `baud_tick_gen`

## Requirements
- R1: With fraction 0, consecutive ticks are exactly the whole part of the active divisor apart, in clocks.
- R2: Over any 64 consecutive tick intervals after the first one following enable, the total clock count equals 64 times the whole part plus the fraction. The fraction is taken from write-data bits [5:0].
- R3: Each interval is the whole part, or the whole part plus one. A period is stretched exactly when adding the fraction into a 6-bit accumulator at the previous tick carried out. The accumulator starts at zero.
- R4: Writes to the whole-part strobe (data bits [15:0]) and the fraction strobe do not change the tick spacing until the line-control strobe is written.
- R5: A control write with data bit 0 set enables an idle block and clears the phase. The first tick comes a whole part's worth of clocks after the clock before the accepting edge, and the fraction sequence restarts from zero.
- R6: A control write with bit 0 clear while busy is high keeps ticks and active running. Active drops on the first edge at which busy is seen low.
- R7: A control write with bit 0 clear while busy is low drops active at the accepting edge, and no tick follows.
- R8: While the active whole part is zero, no tick is produced, though the block stays active.
- R9: Tick is never high while active is low. When the whole part is 2 or more, tick is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_int | input | 1 | Stage whole divisor part from wr_data[15:0] |
| wr_frac | input | 1 | Stage fractional divisor part from wr_data[5:0] |
| wr_lcr | input | 1 | Line-control write; makes the staged divisor active |
| wr_ctl | input | 1 | Control write; wr_data[0] is the enable bit |
| wr_data | input | 16 | Write data shared by all strobes |
| busy | input | 1 | A character is in flight in the transmit or receive engine |
| tick | output | 1 | One-clock strobe at sixteen times the bit rate |
| active | output | 1 | Block is generating ticks (running or draining) |

## Verification
The hardest case to reach is the drain. The enable bit must be cleared in the middle of a run while busy is high. Ticks must then keep their exact spacing, and active must fall on the first edge that sees busy low. The stimulus queues the expected intervals ahead of time and clears the enable bit after part of them have arrived. It holds busy until the queue is empty, then releases busy and checks that active falls one edge later with no stray tick. Accumulator wraparound is reached with a fraction of 54 over 65 intervals, so the carry pattern goes through a full cycle.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
    localparam int DATA_W = 16;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 6;
    localparam int PER_W  = INT_W + 1;

    typedef struct packed {
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } div_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_st_e;

    function automatic logic div_usable(div_t d);
        return d.ipart != '0;
    endfunction
endpackage

// File: rtl/bdg_div_regs.sv
module bdg_div_regs
    import bdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_int,
    input  logic              wr_frac,
    input  logic              wr_lcr,
    input  logic [DATA_W-1:0] wr_data,
    output div_t              act_div
);
    div_t stage_q;
    div_t stage_nxt;

    always_comb begin
        stage_nxt = stage_q;
        if (wr_int)  stage_nxt.ipart = wr_data[INT_W-1:0];
        if (wr_frac) stage_nxt.fpart = wr_data[FRAC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            act_div <= '0;
        end else begin
            stage_q <= stage_nxt;
            if (wr_lcr) act_div <= stage_nxt;
        end
    end

    assert_staged_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_lcr |=> $stable(act_div));
endmodule

// File: rtl/bdg_run_ctrl.sv
module bdg_run_ctrl
    import bdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_ctl,
    input  logic en_bit,
    input  logic busy,
    output logic active,
    output logic restart
);
    run_st_e st_q, st_nxt;

    always_comb begin
        st_nxt  = st_q;
        restart = 1'b0;
        unique case (st_q)
            ST_IDLE: if (wr_ctl && en_bit) begin
                st_nxt  = ST_RUN;
                restart = 1'b1;
            end
            ST_RUN: if (wr_ctl && !en_bit) st_nxt = busy ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: begin
                if (wr_ctl && en_bit) st_nxt = ST_RUN;
                else if (!busy)       st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nxt;
    end

    assign active = (st_q != ST_IDLE);

    assert_stop_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> !$past(busy));
    assert_drain_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (active && busy && !(wr_ctl && en_bit)) |=> active);
endmodule

// File: rtl/bdg_tick_core.sv
module bdg_tick_core
    import bdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic clear,
    input  div_t div,
    output logic tick
);
    logic [INT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic              extra_q;
    logic [PER_W-1:0]  period;
    logic [FRAC_W:0]   acc_sum;
    logic              running;
    logic              hit;

    assign running = active && div_usable(div);
    assign period  = {1'b0, div.ipart} + PER_W'(extra_q);
    assign acc_sum = {1'b0, acc_q} + {1'b0, div.fpart};
    assign hit     = running && (({1'b0, cnt_q} + PER_W'(1)) >= period);
    assign tick    = hit;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (!div_usable(div)) begin
            cnt_q   <= '0;
        end else if (hit) begin
            cnt_q   <= '0;
            acc_q   <= acc_sum[FRAC_W-1:0];
            extra_q <= acc_sum[FRAC_W];
        end else if (running) begin
            cnt_q   <= cnt_q + INT_W'(1);
        end
    end

    assert_no_tick_idle_R9: assert property (@(posedge clk) disable iff (rst)
        tick |-> active);
    assert_no_tick_zero_div_R8: assert property (@(posedge clk) disable iff (rst)
        (div.ipart == '0) |-> !tick);
    assert_single_width_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && div.ipart > INT_W'(1)) |=> (!tick || div != $past(div)));
    assert_period_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (running && !clear) |-> ({1'b0, cnt_q} < PER_W'(div.ipart) + PER_W'(1) || $changed(div)));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import bdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_int,
    input  logic              wr_frac,
    input  logic              wr_lcr,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              tick,
    output logic              active
);
    div_t act_div;
    logic restart;
    logic core_clear;

    bdg_div_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_int  (wr_int),
        .wr_frac (wr_frac),
        .wr_lcr  (wr_lcr),
        .wr_data (wr_data),
        .act_div (act_div)
    );

    bdg_run_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl  (wr_ctl),
        .en_bit  (wr_data[0]),
        .busy    (busy),
        .active  (active),
        .restart (restart)
    );

    assign core_clear = restart || (wr_lcr && !active);

    bdg_tick_core u_core (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .clear  (core_clear),
        .div    (act_div),
        .tick   (tick)
    );
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_int = 1'b0, wr_frac = 1'b0, wr_lcr = 1'b0, wr_ctl = 1'b0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        tick, active;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last = 0;
    int exp_q[$];
    int meas_q[$];
    int ticks_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    baud_tick_gen i_baud_tick_gen (
        .clk(clk), .rst(rst), .wr_int(wr_int), .wr_frac(wr_frac),
        .wr_lcr(wr_lcr), .wr_ctl(wr_ctl), .wr_data(wr_data),
        .busy(busy), .tick(tick), .active(active)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int got, input int want);
        n_cmp++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    // Monitor: pop the expected interval on each tick and compare
    always @(negedge clk) begin
        if (!rst && tick) begin
            ticks_seen++;
            check("R9 tick only while active", int'(active), 1);
            if (exp_q.size() == 0) begin
                check("R9/R7/R8 unexpected tick", 1, 0);
            end else begin
                int want;
                want = exp_q.pop_front();
                check("R1/R3 tick interval", cyc - last, want);
                meas_q.push_back(cyc - last);
            end
            last = cyc;
        end
    end

    task automatic wr(input int which, input int data);
        @(negedge clk);
        wr_data = 16'(data);
        case (which)
            0: wr_int = 1'b1;
            1: wr_frac = 1'b1;
            2: wr_lcr = 1'b1;
            default: wr_ctl = 1'b1;
        endcase
        if (which == 3 && data == 1) last = cyc;
        @(negedge clk);
        {wr_int, wr_frac, wr_lcr, wr_ctl} = '0;
    endtask

    task automatic program_div(input int ip, input int fp);
        wr(0, ip);
        wr(1, fp);
        wr(2, 0);
    endtask

    // Driver: push the expected intervals of n periods from a cleared phase
    task automatic push_model(input int ip, input int fp, input int n);
        int acc = 0;
        int extra = 0;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(ip + extra);
            acc = acc + fp;
            extra = acc / 64;
            acc = acc % 64;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int sum;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset tick", int'(tick), 0);
        check("R7 reset active", int'(active), 0);

        // R2/R3/R5: 10 + 54/64 over a full accumulator cycle
        program_div(10, 54);
        push_model(10, 54, 65);
        meas_q.delete();
        wr(3, 1);
        wait (exp_q.size() == 0);
        sum = 0;
        for (int k = 1; k < 65; k++) sum += meas_q[k];
        check("R2 sum of 64 intervals", sum, 64 * 10 + 54);
        for (int k = 0; k < 65; k++)
            check("R3 interval is whole or whole+1", int'(meas_q[k] == 10 || meas_q[k] == 11), 1);

        // R7: disable without busy
        wr(3, 0);
        check("R7 active drops", int'(active), 0);
        repeat (30) @(negedge clk);
        check("R7 stays idle", int'(active), 0);

        // R1 integer-only spacing
        program_div(7, 0);
        push_model(7, 0, 10);
        wr(3, 1);
        wait (exp_q.size() == 5);
        wr(0, 5);                 // R4: staged only
        wr(1, 0);
        wait (exp_q.size() == 0);
        wr(3, 0);
        push_model(7, 0, 3);      // R4: re-enable without latch keeps 7
        wr(3, 1);
        wait (exp_q.size() == 0);
        wr(3, 0);
        wr(2, 0);                 // R4: latch now
        push_model(5, 0, 5);
        wr(3, 1);
        wait (exp_q.size() == 0);
        wr(3, 0);

        // R8: zero whole part
        program_div(0, 20);
        ticks_seen = 0;
        wr(3, 1);
        repeat (50) @(negedge clk);
        check("R8 active with zero divisor", int'(active), 1);
        check("R8 no ticks with zero divisor", ticks_seen, 0);
        wr(3, 0);

        // R5: restart clears the fractional phase
        program_div(6, 32);
        push_model(6, 32, 3);
        wr(3, 1);
        wait (exp_q.size() == 0);
        wr(3, 0);
        push_model(6, 32, 4);
        wr(3, 1);
        wait (exp_q.size() == 0);
        wr(3, 0);

        // R6: drain while busy
        program_div(4, 0);
        busy = 1'b1;
        push_model(4, 0, 6);
        wr(3, 1);
        wait (exp_q.size() == 3);
        wr(3, 0);
        @(negedge clk);
        check("R6 active while draining", int'(active), 1);
        wait (exp_q.size() == 0);
        check("R6 active until busy drops", int'(active), 1);
        busy = 1'b0;
        @(negedge clk);
        check("R6 stops after busy drops", int'(active), 0);
        repeat (20) @(negedge clk);
        check("R6 no stray tick after drain", int'(active), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule